// File: doc/BRIEF.md
# Saturating Receive Error Tally Bank

This block keeps three independent 8-bit tallies of receive-side fault events for a network controller: misaligned frames, frames whose checksum failed, and packets dropped for lack of buffer space. Receive logic raises a one-cycle pulse on the matching event input each time a fault is seen. Each tally climbs by one per pulse and stops at 192 instead of wrapping.

A host reads a tally by presenting its index with a one-cycle read strobe. The value is returned on a registered data output one cycle later, and the same read zeroes that tally. If an event arrives in the cycle of the read, the event is kept: the host sees the old value and the tally restarts at one. The other tallies are not touched by the read.

Top module: `rx_err_tally`

## Requirements
- R1: A synchronous active-low reset zeroes all three tallies and the read data output.
- R2: Each pulse on an event input raises its tally by one. Input bit 0 is frame alignment errors, bit 1 is checksum errors and bit 2 is missed packets, each matched to read index 0, 1 and 2.
- R3: A tally never goes above 192 (0xC0). A pulse when it holds 192 leaves it at 192.
- R4: A read with the strobe high returns the tally's unsigned binary value on rd_data in the cycle after the strobe, and rd_data holds that value until the next read.
- R5: A read zeroes the tally it reads, so a second read with no events between them returns 0.
- R6: A pulse for a tally in the cycle that tally is read is not lost: the read returns the old value and the tally becomes 1 (the read data shows the value before the pulse).
- R7: A read leaves the other two tallies unchanged, and pulses to them in the read cycle still count.
- R8: A read of index 3 returns 0 and changes no tally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 3 | One-cycle event pulses, one bit per tally |
| rd_stb | input | 1 | Host read strobe, one cycle |
| rd_idx | input | 2 | Index of the tally to read |
| rd_data | output | 8 | Registered read data, valid one cycle after the strobe |

## Verification
On every cycle the assertions check that no tally goes above the ceiling, that a tally moves only by one step up, stays still, or drops to zero or one on a read, and that an unread tally never drops. They also check that the read data follows the strobe by one cycle and keeps its value between reads. The exact value returned, whether an event that collides with a read survives, and the behaviour of the spare index are shown only by the bench. It compares random and directed traffic against its own model of each tally.

// File: rtl/rx_err_tally_pkg.sv
// Package: shared widths and limits for the receive error tally bank.
// Assumes: tallies are unsigned and the ceiling fits in the tally width.
package rx_err_tally_pkg;
    localparam int unsigned TALLY_W   = 8;
    localparam int unsigned TALLY_N   = 3;
    localparam int unsigned IDX_W     = 2;
    localparam logic [TALLY_W-1:0] TALLY_CEIL = 8'd192;

    // Which operation a tally performs in a given cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_CLR   = 2'd2,
        OP_RESTART = 2'd3
    } tally_op_e;
endpackage

// File: rtl/rx_err_tally_cell.sv
// Module: one saturating tally that is zeroed when read.
// Assumes: evt and clr are single-cycle pulses in the clk domain; a clear
// together with an event restarts the tally at one so no event is lost.
module rx_err_tally_cell
    import rx_err_tally_pkg::*;
#(
    parameter int unsigned W    = TALLY_W,
    parameter logic [W-1:0] CEIL = W'(TALLY_CEIL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = W'(1);

    tally_op_e op;
    logic      at_ceil;

    // Decode the action for this cycle from the event and clear pulses
    always_comb begin
        at_ceil = (count >= CEIL);
        unique case ({clr, evt})
            2'b00:   op = OP_HOLD;
            2'b01:   op = at_ceil ? OP_HOLD : OP_INC;
            2'b10:   op = OP_CLR;
            default: op = OP_RESTART;
        endcase
    end

    // Update the tally register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (op)
                OP_INC:     count <= count + ONE;
                OP_CLR:     count <= '0;
                OP_RESTART: count <= ONE;
                default:    count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CEIL);  // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && $past(rst_n)) |=> (count == $past(count) || count == $past(count) + ONE));  // R2
    AST_CLR_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == (($past(evt)) ? ONE : '0)));  // R6
    AST_HOLD_AT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CEIL && !clr) |=> (count == CEIL));  // R3
endmodule

// File: rtl/rx_err_tally_rdport.sv
// Module: host read port; decodes the index into clear pulses and registers
// the selected tally. Assumes rd_stb is one cycle wide; unused indices read 0.
module rx_err_tally_rdport
    import rx_err_tally_pkg::*;
#(
    parameter int unsigned W   = TALLY_W,
    parameter int unsigned N   = TALLY_N,
    parameter int unsigned IW  = IDX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rd_stb,
    input  logic [IW-1:0]  rd_idx,
    input  logic [W-1:0]   counts [N],
    output logic [N-1:0]   clr,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] sel;

    // One clear pulse per tally, raised only for the addressed tally
    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr[g] = rd_stb && (rd_idx == IW'(g));
    end

    // Select the addressed tally, or zero for an unused index
    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IW'(i)) sel = counts[i];
        end
    end

    // Capture read data on a strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= sel;
    end

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));  // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && $past(rst_n)) |=> $stable(rd_data));  // R4
endmodule

// File: rtl/rx_err_tally.sv
// Module: top of the receive error tally bank. Three saturating tallies fed
// by event pulses, read and cleared through a strobe/index port.
// Assumes: all inputs synchronous to clk; reset is synchronous active-low.
module rx_err_tally
    import rx_err_tally_pkg::*;
#(
    parameter int unsigned W  = TALLY_W,
    parameter int unsigned N  = TALLY_N,
    parameter int unsigned IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt_pulse,
    input  logic          rd_stb,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] counts [N];
    logic [N-1:0] clr;

    // One tally cell per event source
    for (genvar g = 0; g < N; g++) begin : g_cell
        rx_err_tally_cell #(.W(W), .CEIL(W'(TALLY_CEIL))) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_pulse[g]),
            .clr   (clr[g]),
            .count (counts[g])
        );

        AST_UNREAD_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[g] && $past(rst_n)) |=> (counts[g] >= $past(counts[g])));  // R7
    end

    rx_err_tally_rdport #(.W(W), .N(N), .IW(IW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .rd_idx  (rd_idx),
        .counts  (counts),
        .clr     (clr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/rx_err_tally_tb.sv
module rx_err_tally_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] evt_pulse = '0;
    logic       rd_stb = 0;
    logic [1:0] rd_idx = '0;
    logic [7:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int model [3];

    always #5 clk = ~clk;

    rx_err_tally u_dut (.clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
                        .rd_stb(rd_stb), .rd_idx(rd_idx), .rd_data(rd_data));

    function automatic int sat_inc(input int v);
        return (v >= 192) ? 192 : v + 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: apply events and optional read, update model, check data
    task automatic step(input logic [2:0] ev, input logic rd, input logic [1:0] idx,
                        input string req);
        int exp_rd;
        exp_rd = -1;
        evt_pulse = ev; rd_stb = rd; rd_idx = idx;
        if (rd) exp_rd = (idx < 3) ? model[idx] : 0;
        for (int i = 0; i < 3; i++) begin
            if (rd && idx == 2'(i)) model[i] = ev[i] ? 1 : 0;
            else if (ev[i]) model[i] = sat_inc(model[i]);
        end
        @(posedge clk); #1;
        evt_pulse = '0; rd_stb = 0;
        if (exp_rd >= 0) check(req, rd_data, exp_rd);
    endtask

    task automatic read_chk(input logic [1:0] idx, input string req);
        step(3'b000, 1'b1, idx, req);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [1:0] last;
        process::self().srandom(32'd1234);
        for (int i = 0; i < 3; i++) model[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", rd_data, 0);
        rst_n = 1;
        for (int i = 0; i < 3; i++) read_chk(2'(i), "R1");

        // R2: distinct counts per source
        for (int k = 0; k < 5; k++) step(3'b001, 0, 0, "R2");
        for (int k = 0; k < 9; k++) step(3'b010, 0, 0, "R2");
        for (int k = 0; k < 2; k++) step(3'b100, 0, 0, "R2");
        read_chk(2'd1, "R2"); read_chk(2'd0, "R2"); read_chk(2'd2, "R2");
        // R5: second read gives zero
        read_chk(2'd1, "R5");
        // R4: data holds without strobe
        step(3'b111, 0, 0, "R4");
        check("R4", rd_data, 0);
        // R3: saturation
        for (int k = 0; k < 250; k++) step(3'b001, 0, 0, "R3");
        read_chk(2'd0, "R3");
        for (int k = 0; k < 192; k++) step(3'b100, 0, 0, "R3");
        step(3'b100, 0, 0, "R3");
        read_chk(2'd2, "R3");
        // R6: event collides with read
        step(3'b010, 0, 0, "R6"); step(3'b010, 0, 0, "R6");
        step(3'b010, 1, 2'd1, "R6");
        read_chk(2'd1, "R6");
        // R7: read one tally, others count in same cycle
        step(3'b101, 0, 0, "R7");
        step(3'b101, 1, 2'd1, "R7");
        read_chk(2'd0, "R7"); read_chk(2'd2, "R7");
        // R8: spare index
        step(3'b011, 0, 0, "R8");
        read_chk(2'd3, "R8");
        read_chk(2'd0, "R8"); read_chk(2'd1, "R8");
        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            last = 2'($urandom_range(0, 3));
            step(3'($urandom), ($urandom_range(0, 7) == 0), last, "R2/R6 random");
        end
        for (int i = 0; i < 4; i++) read_chk(2'(i), "R4 final");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule